// File: doc/BRIEF.md
# Guarded DMA Control and Status Register

This block holds the 32-bit control and status word of a multi-channel DMA engine. Software writes it to start and stop the engine, to set how many channels are in use and to enable the interrupt. The DMA datapath reports error events and per-channel descriptor-completion interrupts into it. The channel count and the interrupt enable are protected: they change only on a write whose top bit is one. A write without that bit leaves them alone.

Status bits are sticky. Each stays set until software writes a one to it. If the engine raises a status bit in the same cycle that software clears it, the bit stays set, so no event is lost. Start and stop are one-cycle command pulses toward the engine. The block drives a single interrupt output, which is the interrupt enable combined with the channel status bits.

Top module: `dma_guarded_csr`

## Requirements
- R1: After reset, rd_data reads 0x00000000 and irq, start_pulse and stop_pulse are low.
- R2: A write with wr_data[31]=1 loads the channel count from wr_data[6:4] and the interrupt enable from wr_data[1]. Both are visible in rd_data at the same bit positions on the cycle after the write.
- R3: A write with wr_data[31]=0 leaves the channel count and the interrupt enable unchanged.
- R4: A one on chan_irq_set[n] sets channel status bit rd_data[12+n] on the next cycle. A write of one to that bit clears it. A write of zero to it has no effect.
- R5: Error event inputs err_set[4:0] map to sticky flags at rd_data[7+i]. Bit 4 is master abort (bit 11), bit 3 is target abort (bit 10), bit 2 is parity error (bit 9), bit 1 is data-bus error (bit 8) and bit 0 is descriptor-fetch error (bit 7). Each flag is cleared by writing one to it.
- R6: When a set event and a write-one-to-clear reach the same status bit in one cycle, the bit is set afterwards.
- R7: A write with wr_data[0]=1 gives a one-cycle start_pulse, and a write with wr_data[2]=1 gives a one-cycle stop_pulse, both on the cycle after the write. When both bits are written together, only stop_pulse fires. Bits 0 and 2 read as zero.
- R8: rd_data[3] follows the engine_active input in the same cycle.
- R9: rd_data[31:20] always read as zero. This includes the guard bit.
- R10: irq is high exactly when the interrupt enable is set and at least one channel status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| engine_active | input | 1 | Engine busy indicator |
| chan_irq_set | input | CH | Per-channel interrupt events |
| err_set | input | 5 | Error events (master abort, target abort, parity, data bus, descriptor) |
| start_pulse | output | 1 | One-cycle start command |
| stop_pulse | output | 1 | One-cycle stop command |
| irq_enable | output | 1 | Stored interrupt enable |
| chan_count | output | 3 | Stored channel count |
| irq | output | 1 | Combined interrupt |

## Verification
Two of this block's functions can fall in the same cycle. One is a hardware set event on a status bit. The other is a software write-one-to-clear of that same bit. The bench provokes this by driving a channel event and an error event in the same cycle as a write that clears those exact bits, alongside other bits that are only cleared. It judges the result from the read-back word: the colliding bit must remain set while its neighbours clear. Start and stop written together form a second collision, and it is judged on the two pulse outputs.

// File: rtl/dma_guarded_csr.sv
module dma_guarded_csr #(
  parameter int CH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  output logic [31:0]   rd_data,
  input  logic          engine_active,
  input  logic [CH-1:0] chan_irq_set,
  input  logic [4:0]    err_set,
  output logic          start_pulse,
  output logic          stop_pulse,
  output logic          irq_enable,
  output logic [2:0]    chan_count,
  output logic          irq
);
  localparam int CH_LSB  = 12;
  localparam int ERR_LSB = 7;
  localparam int NERR    = 5;

  logic [CH-1:0]   ch_st;
  logic [NERR-1:0] err_st;
  logic            guard_ok;
  logic [CH-1:0]   ch_clr;
  logic [NERR-1:0] err_clr;

  assign guard_ok = wr_en & wr_data[31];
  assign ch_clr   = wr_en ? wr_data[CH_LSB +: CH] : '0;
  assign err_clr  = wr_en ? wr_data[ERR_LSB +: NERR] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_st       <= '0;
      err_st      <= '0;
      irq_enable  <= 1'b0;
      chan_count  <= 3'd0;
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
    end else begin
      ch_st       <= chan_irq_set | (ch_st & ~ch_clr);
      err_st      <= err_set | (err_st & ~err_clr);
      start_pulse <= wr_en & wr_data[0] & ~wr_data[2];
      stop_pulse  <= wr_en & wr_data[2];
      if (guard_ok) begin
        irq_enable <= wr_data[1];
        chan_count <= wr_data[6:4];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[CH_LSB +: CH]    = ch_st;
    rd_data[ERR_LSB +: NERR] = err_st;
    rd_data[6:4]             = chan_count;
    rd_data[3]               = engine_active;
    rd_data[1]               = irq_enable;
  end

  assign irq = irq_enable & (|ch_st);

  initial assert (CH >= 1 && CH <= 8) else $error("CH out of range");

  assert_guard_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[31]) |=> ($stable(irq_enable) && $stable(chan_count)));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_irq_set) |=> ((rd_data[CH_LSB +: CH] & $past(chan_irq_set)) == $past(chan_irq_set)));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_set) |=> ((rd_data[ERR_LSB +: NERR] & $past(err_set)) == $past(err_set)));

  assert_cmd_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && stop_pulse));

  assert_start_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(wr_en && wr_data[0] && !wr_data[2]));

  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_data[1] && (|rd_data[CH_LSB +: CH])));
endmodule

// File: tb/tb_dma_guarded_csr.sv
module tb_dma_guarded_csr;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        engine_active = 1'b0;
  logic [7:0]  chan_irq_set = '0;
  logic [4:0]  err_set = '0;
  logic        start_pulse, stop_pulse, irq_enable, irq;
  logic [2:0]  chan_count;

  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_guarded_csr #(.CH(8)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .engine_active(engine_active), .chan_irq_set(chan_irq_set), .err_set(err_set),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse), .irq_enable(irq_enable),
    .chan_count(chan_count), .irq(irq)
  );

  // stimulus: {wr_en, wr_data, chan_irq_set, err_set, engine_active}
  localparam logic [46:0] STIM [NV] = '{
    {1'b1, 32'h8000_0032, 8'h00, 5'b00000, 1'b0},
    {1'b1, 32'h0000_0040, 8'h00, 5'b00000, 1'b0},
    {1'b0, 32'h0000_0000, 8'h05, 5'b00000, 1'b0},
    {1'b1, 32'h0000_1000, 8'h00, 5'b00000, 1'b0},
    {1'b0, 32'h0000_0000, 8'h00, 5'b10001, 1'b0},
    {1'b1, 32'h0000_4800, 8'h04, 5'b00000, 1'b0},
    {1'b1, 32'h0000_4080, 8'h00, 5'b00000, 1'b0},
    {1'b1, 32'h0000_0001, 8'h00, 5'b00000, 1'b0},
    {1'b1, 32'h0000_0005, 8'h00, 5'b00000, 1'b0},
    {1'b0, 32'h0000_0000, 8'h00, 5'b00000, 1'b1},
    {1'b1, 32'hFFF0_0000, 8'h00, 5'b00000, 1'b0},
    {1'b0, 32'h0000_0000, 8'h00, 5'b01110, 1'b0},
    {1'b0, 32'h0000_0000, 8'h80, 5'b00000, 1'b0},
    {1'b1, 32'h0000_0700, 8'h00, 5'b00010, 1'b0}
  };
  // expected: {rd_data, irq, start_pulse, stop_pulse}
  localparam logic [34:0] EXPV [NV] = '{
    {32'h0000_0032, 3'b000},
    {32'h0000_0032, 3'b000},
    {32'h0000_5032, 3'b100},
    {32'h0000_4032, 3'b100},
    {32'h0000_48B2, 3'b100},
    {32'h0000_40B2, 3'b100},
    {32'h0000_0032, 3'b000},
    {32'h0000_0032, 3'b010},
    {32'h0000_0032, 3'b001},
    {32'h0000_003A, 3'b000},
    {32'h0000_0000, 3'b000},
    {32'h0000_0700, 3'b000},
    {32'h0008_0700, 3'b000},
    {32'h0008_0100, 3'b000}
  };
  localparam string TAG [NV] = '{
    "R2", "R3", "R4 R10", "R4", "R5", "R6", "R5 R10",
    "R7", "R7", "R8", "R9 R2", "R5", "R10", "R6 R5"
  };

  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got rd=%h irq/start/stop=%b, expected rd=%h irq/start/stop=%b",
               tag, act[34:3], act[2:0], exp[34:3], exp[2:0]);
    end
  endtask

  function automatic logic [34:0] observe();
    return {rd_data, irq, start_pulse, stop_pulse};
  endfunction

  task automatic step(input logic [46:0] s);
    @(negedge clk);
    {wr_en, wr_data, chan_irq_set, err_set, engine_active} = s;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", observe(), 35'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(STIM[i]);
      check(TAG[i], observe(), EXPV[i]);
    end

    // R7: start pulse lasts one cycle
    step({1'b1, 32'h0000_0001, 8'h00, 5'b00000, 1'b0});
    check("R7 start", observe(), {32'h0008_0100, 3'b010});
    step(47'd0);
    check("R7 start ends", observe(), {32'h0008_0100, 3'b000});

    // R3: unguarded write leaves enable clear, irq stays low with channel bit set
    step({1'b1, 32'h0000_0072, 8'h00, 5'b00000, 1'b0});
    check("R3 unguarded", observe(), {32'h0008_0100, 3'b000});
    check("R3 outputs", {32'd0, irq_enable, chan_count}, {32'd0, 1'b0, 3'd0});

    // R10: guarded enable raises irq with a pending channel bit
    step({1'b1, 32'h8000_0072, 8'h00, 5'b00000, 1'b0});
    check("R10 enable", observe(), {32'h0008_0172, 3'b100});

    // R1: reset in the middle of activity
    @(negedge clk);
    rst_n = 1'b0;
    {wr_en, wr_data, chan_irq_set, err_set, engine_active} = '0;
    @(posedge clk);
    #1;
    check("R1 mid reset", observe(), 35'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule